// File: doc/BRIEF.md
# Chainable Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit of parameterised width (8 bits by default). It takes two operands, a flag-in word and a 3-bit operation code. It returns a result word and a flag-out word. Eight functions are offered:

- plain addition and plain subtraction;
- addition that takes in a carry, and subtraction that takes in a borrow;
- AND, OR and XOR of the two operands;
- the bitwise complement of the first operand.

Carry and borrow are held as two distinct flag bits. Each bit is read from the same flag-in position that the flag-out word writes it to. An outer flag register can therefore feed the flag-out word straight back as flag-in, and operations wider than the datapath are built from a chain of word-sized steps. The top bit of the operation code works as the chain enable for the arithmetic operations. When that bit is clear, the incoming flag is treated as zero.

Inside the block, a decoder turns the operation code into a small set of control strobes. A datapath holds:

- a ripple adder;
- a ripple subtractor;
- a logic unit;
- the result and flag selection.

Top module: `alu_chain`

## Requirements
- R1: The flag-out word carries the carry at bit 0 and the borrow at bit 1. Every flag-out bit above bit 1 is always 0.
- R2: Code 3'b000 (add) gives result = (P + Q) mod 2^W, and flag-out bit 0 = bit W of P + Q. Every flag-in bit is ignored.
- R3: Code 3'b001 (subtract) gives result = (P - Q) mod 2^W, and flag-out bit 1 = 1 exactly when P < Q. Every flag-in bit is ignored.
- R4: Code 3'b100 (add with carry) gives result = (P + Q + flagIn[0]) mod 2^W, and flag-out bit 0 = bit W of that sum.
- R5: Code 3'b101 (subtract with borrow) gives result = (P - Q - flagIn[1]) mod 2^W, and flag-out bit 1 = 1 exactly when P - Q - flagIn[1] is negative.
- R6: Code 3'b010 gives P AND Q. Code 3'b011 gives P OR Q. Code 3'b110 gives P XOR Q. Code 3'b111 gives NOT P, and Q has no effect on it.
- R7: The four logic codes (3'b010, 3'b011, 3'b110, 3'b111) drive flag-out bits 0 and 1 to 0.
- R8: The addition codes drive flag-out bit 1 to 0, and the subtraction codes drive flag-out bit 0 to 0.
- R9: Add with carry ignores flag-in bit 1 and all higher flag-in bits. Subtract with borrow ignores flag-in bit 0 and all higher flag-in bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation code |
| opP | input | W | First operand |
| opQ | input | W | Second operand |
| flagIn | input | FW | Incoming flags: carry at bit 0, borrow at bit 1 |
| result | output | W | Operation result |
| flagOut | output | FW | Outgoing flags: carry at bit 0, borrow at bit 1, the rest 0 |

## Verification
The bench goes after the chain boundaries, each tied to a failure it would expose:

- An all-ones sum with a carry in must wrap to zero with the carry set. A design that drops the top carry would report no overflow.
- A zero-minus-zero with a borrow in must give all ones with the borrow set. A design that computes the borrow from P < Q alone would miss this case.
- A plain add or subtract receives set flag-in bits. A design that always honours the incoming flag would be off by one here.
- Add with carry is given only the borrow bit, and subtract with borrow only the carry bit. A design that reads either flag from the wrong position would fail these.
- Every logic code is applied with flags set in and a varied Q. This catches stale flags leaking through, and a complement that depends on Q.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

  localparam int CARRY_BIT  = 0;
  localparam int BORROW_BIT = 1;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_ADC = 3'b100,
    OP_SBB = 3'b101,
    OP_XOR = 3'b110,
    OP_NOT = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOT = 2'd3
  } logicFn_e;

  typedef enum logic [1:0] {
    RS_ADD   = 2'd0,
    RS_SUB   = 2'd1,
    RS_LOGIC = 2'd2
  } resSrc_e;

  typedef struct packed {
    logic     carryEn;
    logic     borrowEn;
    resSrc_e  resSrc;
    logicFn_e logicFn;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;
  assign carry[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b[i] ^ carry[i];
    assign carry[i+1] = (a[i] & b[i]) | ((a[i] ^ b[i]) & carry[i]);
  end

  assign cout = carry[W];
endmodule

// File: rtl/alu_ripple_sub.sv
module alu_ripple_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         bin,
  output logic [W-1:0] diff,
  output logic         bout
);
  logic [W:0] borrow;
  assign borrow[0] = bin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i]     = a[i] ^ b[i] ^ borrow[i];
    assign borrow[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & borrow[i]);
  end

  assign bout = borrow[W];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_chain_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logicFn_e     fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_chain_pkg::*;
(
  input  logic [2:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '{carryEn: 1'b0, borrowEn: 1'b0, resSrc: RS_LOGIC, logicFn: LG_AND};
    unique case (aluOp_e'(opSel))
      OP_ADD: ctrl.resSrc = RS_ADD;
      OP_SUB: ctrl.resSrc = RS_SUB;
      OP_ADC: begin
        ctrl.resSrc  = RS_ADD;
        ctrl.carryEn = 1'b1;
      end
      OP_SBB: begin
        ctrl.resSrc   = RS_SUB;
        ctrl.borrowEn = 1'b1;
      end
      OP_AND: ctrl.logicFn = LG_AND;
      OP_OR:  ctrl.logicFn = LG_OR;
      OP_XOR: ctrl.logicFn = LG_XOR;
      default: ctrl.logicFn = LG_NOT;
    endcase
  end
endmodule

// File: rtl/alu_dpath.sv
module alu_dpath
  import alu_chain_pkg::*;
#(
  parameter int W  = 8,
  parameter int FW = 4
) (
  input  aluCtrl_t      ctrl,
  input  logic [W-1:0]  opP,
  input  logic [W-1:0]  opQ,
  input  logic          carryFlag,
  input  logic          borrowFlag,
  output logic [W-1:0]  result,
  output logic [FW-1:0] flagOut
);
  logic [W-1:0] sumVal, diffVal, logicVal;
  logic         carryOut, borrowOut;
  logic         carryIn, borrowIn;

  assign carryIn  = ctrl.carryEn  & carryFlag;
  assign borrowIn = ctrl.borrowEn & borrowFlag;

  alu_ripple_add #(.W(W)) u_add (
    .a(opP), .b(opQ), .cin(carryIn), .sum(sumVal), .cout(carryOut)
  );

  alu_ripple_sub #(.W(W)) u_sub (
    .a(opP), .b(opQ), .bin(borrowIn), .diff(diffVal), .bout(borrowOut)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a(opP), .b(opQ), .fn(ctrl.logicFn), .y(logicVal)
  );

  always_comb begin
    flagOut = '0;
    unique case (ctrl.resSrc)
      RS_ADD: begin
        result             = sumVal;
        flagOut[CARRY_BIT] = carryOut;
      end
      RS_SUB: begin
        result              = diffVal;
        flagOut[BORROW_BIT] = borrowOut;
      end
      default: result = logicVal;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_chain_pkg::*;
#(
  parameter int W  = 8,
  parameter int FW = 4
) (
  input  logic [2:0]    opSel,
  input  logic [W-1:0]  opP,
  input  logic [W-1:0]  opQ,
  input  logic [FW-1:0] flagIn,
  output logic [W-1:0]  result,
  output logic [FW-1:0] flagOut
);
  aluCtrl_t ctrl;

  if (FW > 2) begin : g_spareFlags
    logic unusedFlagIn;
    assign unusedFlagIn = ^flagIn[FW-1:2];
  end

  alu_ctrl u_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  alu_dpath #(.W(W), .FW(FW)) u_dpath (
    .ctrl      (ctrl),
    .opP       (opP),
    .opQ       (opQ),
    .carryFlag (flagIn[CARRY_BIT]),
    .borrowFlag(flagIn[BORROW_BIT]),
    .result    (result),
    .flagOut   (flagOut)
  );
endmodule

// File: rtl/alu_chain_chk.sv
module alu_chain_chk #(
  parameter int W  = 8,
  parameter int FW = 4
) (
  input logic [2:0]    opSel,
  input logic [W-1:0]  opP,
  input logic [W-1:0]  opQ,
  input logic [FW-1:0] flagIn,
  input logic [W-1:0]  result,
  input logic [FW-1:0] flagOut
);
  logic [W:0] refAdd, refSub, refAdc, refSbb;
  logic       unusedChkFlags;

  assign unusedChkFlags = ^flagIn;

  always_comb begin
    refAdd = {1'b0, opP} + {1'b0, opQ};
    refSub = {1'b0, opP} - {1'b0, opQ};
    refAdc = {1'b0, opP} + {1'b0, opQ} + {{W{1'b0}}, flagIn[0]};
    refSbb = {1'b0, opP} - {1'b0, opQ} - {{W{1'b0}}, flagIn[1]};

    // R1
    flag_upper_zero_chk: assert ((flagOut >> 2) == '0);
    // R2
    if (opSel == 3'b000) begin
      add_sum_chk: assert ({flagOut[0], result} == refAdd);
    end
    // R3
    if (opSel == 3'b001) begin
      sub_diff_chk: assert (result == refSub[W-1:0] && flagOut[1] == (opP < opQ));
    end
    // R4
    if (opSel == 3'b100) begin
      adc_sum_chk: assert ({flagOut[0], result} == refAdc);
    end
    // R5
    if (opSel == 3'b101) begin
      sbb_diff_chk: assert (result == refSbb[W-1:0] && flagOut[1] == refSbb[W]);
    end
    // R6
    if (opSel == 3'b111) begin
      not_p_chk: assert (result == ~opP);
    end
    // R7
    if (opSel[1]) begin
      logic_flags_chk: assert (flagOut[1:0] == 2'b00);
    end
    // R8
    if (!opSel[1]) begin
      arith_other_flag_chk: assert (opSel[0] ? !flagOut[0] : !flagOut[1]);
    end
  end
endmodule

bind alu_chain alu_chain_chk #(.W(W), .FW(FW)) u_chk (
  .opSel  (opSel),
  .opP    (opP),
  .opQ    (opQ),
  .flagIn (flagIn),
  .result (result),
  .flagOut(flagOut)
);

// File: tb/alu_chain_tb.sv
`timescale 1ns/1ps
module alu_chain_tb;
  localparam int W  = 8;
  localparam int FW = 4;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic [2:0]    opSel = '0;
  logic [W-1:0]  opP = '0, opQ = '0;
  logic [FW-1:0] flagIn = '0;
  logic [W-1:0]  result;
  logic [FW-1:0] flagOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  alu_chain #(.W(W), .FW(FW)) u_dut (
    .opSel(opSel), .opP(opP), .opQ(opQ), .flagIn(flagIn),
    .result(result), .flagOut(flagOut)
  );

  // Table fields: {reqId[3:0], op[2:0], P[7:0], Q[7:0], flagIn[3:0], expRes[7:0], expFlag[3:0]}
  localparam int NVEC = 14;
  localparam logic [38:0] VECS [NVEC] = '{
    {4'd2, 3'b000, 8'h7F, 8'h01, 4'h0, 8'h80, 4'h0}, // R2 no carry
    {4'd2, 3'b000, 8'hFF, 8'h01, 4'hF, 8'h00, 4'h1}, // R2 wrap, flags in ignored
    {4'd3, 3'b001, 8'h05, 8'h07, 4'hF, 8'hFE, 4'h2}, // R3 borrow, flags in ignored
    {4'd3, 3'b001, 8'h10, 8'h10, 4'h2, 8'h00, 4'h0}, // R3 equal operands
    {4'd4, 3'b100, 8'hFF, 8'h00, 4'h1, 8'h00, 4'h1}, // R4 carry ripples out
    {4'd9, 3'b100, 8'h12, 8'h34, 4'h2, 8'h46, 4'h0}, // R9 borrow bit ignored by adc
    {4'd5, 3'b101, 8'h00, 8'h00, 4'h2, 8'hFF, 4'h2}, // R5 zero minus borrow
    {4'd9, 3'b101, 8'h50, 8'h20, 4'h1, 8'h30, 4'h0}, // R9 carry bit ignored by sbb
    {4'd6, 3'b010, 8'hF0, 8'h3C, 4'hF, 8'h30, 4'h0}, // R6 AND, R7 flags clear
    {4'd6, 3'b011, 8'hF0, 8'h0C, 4'h3, 8'hFC, 4'h0}, // R6 OR
    {4'd6, 3'b110, 8'hAA, 8'hFF, 4'h0, 8'h55, 4'h0}, // R6 XOR
    {4'd7, 3'b111, 8'h0F, 8'hFF, 4'h3, 8'hF0, 4'h0}, // R7 NOT with flags in set
    {4'd4, 3'b100, 8'hFF, 8'hFF, 4'h1, 8'hFF, 4'h1}, // R4 maximal sum
    {4'd5, 3'b101, 8'h00, 8'hFF, 4'h2, 8'h00, 4'h2}  // R5 maximal borrow
  };

  function automatic string opReq(input logic [2:0] op);
    case (op)
      3'b000:  return "R2,R8";
      3'b001:  return "R3,R8";
      3'b100:  return "R4,R9";
      3'b101:  return "R5,R9";
      default: return "R6,R7";
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic checkOut(input string req, input logic [W-1:0] expRes,
                          input logic [FW-1:0] expFl);
    nChecks++;
    if (result !== expRes || flagOut !== expFl) begin
      nFails++;
      $display("FAIL %s op=%b P=%h Q=%h F=%h : result %h exp %h, flags %h exp %h",
               req, opSel, opP, opQ, flagIn, result, expRes, flagOut, expFl);
    end
  endtask

  // Reference built from the requirement text.
  task automatic model(input logic [2:0] op, input int p, input int q, input logic [FW-1:0] f,
                       output logic [W-1:0] r, output logic [FW-1:0] fl);
    int v;
    fl = '0;
    case (op)
      3'b000: begin v = p + q;        r = v[W-1:0]; fl[0] = v >= 256; end
      3'b100: begin v = p + q + f[0]; r = v[W-1:0]; fl[0] = v >= 256; end
      3'b001: begin v = p - q;        r = v[W-1:0]; fl[1] = v < 0; end
      3'b101: begin v = p - q - f[1]; r = v[W-1:0]; fl[1] = v < 0; end
      3'b010: r = W'(p & q);
      3'b011: r = W'(p | q);
      3'b110: r = W'(p ^ q);
      default: r = ~W'(p);
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [W-1:0] p, input logic [W-1:0] q,
                       input logic [FW-1:0] f);
    @(posedge clk);
    opSel = op; opP = p; opQ = q; flagIn = f;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: cycles %0d exp below %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    logic [7:0] qPick [8];
    logic [W-1:0] eR;
    logic [FW-1:0] eF;
    qPick = '{8'h00, 8'h01, 8'h0F, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hFF};

    // Idle state: all inputs zero gives add of zeros, R1 upper flags clear.
    @(negedge clk);
    checkOut("R1,R2", '0, '0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][34:32], VECS[i][31:24], VECS[i][23:16], VECS[i][15:12]);
      checkOut($sformatf("R%0d", VECS[i][38:35]), VECS[i][11:4], VECS[i][3:0]);
    end

    // Sweep: every op, all P, chosen Q values, low flag-in patterns plus
    // upper flag bits set (R9 and R1).
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 256; p++) begin
        for (int qi = 0; qi < 8; qi++) begin
          for (int f = 0; f < 4; f++) begin
            logic [FW-1:0] fin;
            fin = FW'(f) | ((p[0] && qi[0]) ? 4'hC : 4'h0);
            model(3'(op), p, int'(qPick[qi]), fin, eR, eF);
            apply(3'(op), W'(p), qPick[qi], fin);
            checkOut(opReq(3'(op)), eR, eF);
          end
        end
      end
    end

    // R6: NOT ignores Q entirely.
    apply(3'b111, 8'h3C, 8'h00, 4'h0);
    checkOut("R6", 8'hC3, 4'h0);
    apply(3'b111, 8'h3C, 8'hA5, 4'hF);
    checkOut("R6", 8'hC3, 4'h0);

    finishRun();
  end
endmodule